// File: doc/BRIEF.md
# Dual-Class Physical Register Free List

This block keeps track of which physical registers a renaming stage may hand out. Integer and floating-point registers share one index space: integer registers take indices `0 .. INT_PHYS-1` and floating-point registers follow right after, taking `INT_PHYS .. INT_PHYS+FP_PHYS-1`. Each class has its own first-in-first-out pool of free indices. A rename stage takes one register per class per cycle through the allocate ports and returns registers through a release port that works out the class from the index, or through one release port per class.

A shadow scoreboard holds one bit per physical register. The bit is set while the register is free. Releasing a register that is already free, or allocating one that is not free, raises a sticky consistency flag. Asking an empty pool for a register returns no valid index and raises its own sticky flag. The block also reports, for each class, whether its pool is non-empty and how many entries it holds.

Top module: `dual_class_free_list`

## Requirements
- R1: After reset the integer pool holds indices `INT_LOG .. INT_PHYS-1` in ascending order and the floating-point pool holds `INT_PHYS+FP_LOG .. INT_PHYS+FP_PHYS-1` in ascending order. Both non-empty flags are high and all three error flags are low.
- R2: An allocation that is granted returns, in the same cycle, the oldest index in that class's pool, and removes it at the next clock edge.
- R3: Granted integer indices are below `INT_PHYS`. Granted floating-point indices lie in `[INT_PHYS, INT_PHYS+FP_PHYS)`.
- R4: On the generic release port, an index below `INT_PHYS` is added to the integer pool and an index in `[INT_PHYS, INT_PHYS+FP_PHYS)` is added to the floating-point pool. Any larger index changes neither pool.
- R5: The class-specific release ports add an index to their own pool only when the index lies in that class's range. Otherwise the index is ignored.
- R6: An allocation and one release on the same class in the same cycle both take effect, and that class's free count stays the same.
- R7: A request to an empty pool keeps the valid output low, drives the index output to 0, and sets `empty_alloc_err` at the next edge.
- R8: Releasing a register whose scoreboard bit is already set sets `dbl_free_err` at the next edge. The index is still added to the pool.
- R9: Granting an index whose scoreboard bit is clear sets `dbl_alloc_err` at the next edge.
- R10: `int_free_cnt` and `fp_free_cnt` equal the number of entries in each pool. Each non-empty flag is high exactly when its count is nonzero.
- R11: All three error flags stay set until reset.
- R12: If the generic port and the class port both release to the same class in one cycle, both indices enter that pool. The generic port's index goes in first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| int_alloc_req | input | 1 | Request one integer register |
| int_alloc_vld | output | 1 | Integer request granted this cycle |
| int_alloc_idx | output | IDX_W | Granted integer index (0 when not granted) |
| fp_alloc_req | input | 1 | Request one floating-point register |
| fp_alloc_vld | output | 1 | Floating-point request granted this cycle |
| fp_alloc_idx | output | IDX_W | Granted floating-point index (0 when not granted) |
| any_rel_en | input | 1 | Generic release strobe |
| any_rel_idx | input | IDX_W | Generic release index; class chosen by range |
| int_rel_en | input | 1 | Integer-port release strobe |
| int_rel_idx | input | IDX_W | Integer-port release index |
| fp_rel_en | input | 1 | Floating-point-port release strobe |
| fp_rel_idx | input | IDX_W | Floating-point-port release index |
| int_nonempty | output | 1 | Integer pool holds at least one index |
| fp_nonempty | output | 1 | Floating-point pool holds at least one index |
| int_free_cnt | output | INT_CNT_W | Entries in the integer pool |
| fp_free_cnt | output | FP_CNT_W | Entries in the floating-point pool |
| empty_alloc_err | output | 1 | Sticky: a request was made to an empty pool |
| dbl_alloc_err | output | 1 | Sticky: a non-free register was granted |
| dbl_free_err | output | 1 | Sticky: an already-free register was released |

## Verification
The assertions check the following on every cycle:
- granted indices stay inside their class range;
- a free count never goes above its pool size;
- an empty request leads to the empty error;
- the error flags stay set;
- an allocation paired with one release leaves the count unchanged;
- an out-of-range generic release changes neither count.

The bench scenarios are the only way to show the rest:
- the exact first-in-first-out order of returned indices, including indices released earlier and two indices pushed in one cycle;
- the contents of the pools after reset;
- double-release and double-grant detection, where a duplicated index has to travel through the pool before it is granted a second time.

// File: rtl/frl_pkg.sv
package frl_pkg;

  // Width of a counter that must hold values 0..n inclusive.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Width of a pointer into a ring of depth entries.
  function automatic int ptr_width(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

  // Kind of request seen by a pool slot in one cycle.
  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_kind_e;

endpackage

// File: rtl/frl_pool.sv
module frl_pool #(
  parameter int IDX_W = 4,
  parameter int DEPTH = 8,
  parameter int BASE  = 0,
  parameter int LOG   = 4,
  parameter int CNT_W = frl_pkg::cnt_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_req,
  output logic             head_vld,
  output logic [IDX_W-1:0] head_idx,
  input  logic             push0_en,
  input  logic [IDX_W-1:0] push0_idx,
  input  logic             push1_en,
  input  logic [IDX_W-1:0] push1_idx,
  output logic [CNT_W-1:0] cnt
);
  import frl_pkg::*;

  localparam int PTR_W     = ptr_width(DEPTH);
  localparam int INIT_FREE = DEPTH - LOG;

  logic [IDX_W-1:0] ring_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_n, wr_q, wr_n, wr1_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W:0]   space, need1;
  logic             pop, acc0, acc1;
  push_kind_e       kind;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // next-state logic
  always_comb begin
    pop     = pop_req && (cnt_q != '0);
    space   = (CNT_W+1)'(DEPTH) - {1'b0, cnt_q} + (CNT_W+1)'(pop);
    acc0    = push0_en && (space != '0);
    need1   = acc0 ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
    acc1    = push1_en && (space >= need1);
    wr1_ptr = acc0 ? ptr_inc(wr_q) : wr_q;
    wr_n    = acc1 ? ptr_inc(wr1_ptr) : wr1_ptr;
    rd_n    = pop ? ptr_inc(rd_q) : rd_q;
    cnt_n   = cnt_q - CNT_W'(pop) + CNT_W'(acc0) + CNT_W'(acc1);
    if (acc0 && acc1)      kind = PUSH_TWO;
    else if (acc0 || acc1) kind = PUSH_ONE;
    else                   kind = PUSH_NONE;
  end

  // pointer and occupancy registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= PTR_W'(INIT_FREE % DEPTH);
      cnt_q <= CNT_W'(INIT_FREE);
    end else begin
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      if (kind != PUSH_NONE) wr_q <= wr_n;
    end
  end

  // storage, one clock enable per slot
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic             we;
    logic [IDX_W-1:0] wd;
    always_comb begin
      we = 1'b0;
      wd = ring_q[s];
      if (acc0 && (wr_q == PTR_W'(s))) begin
        we = 1'b1;
        wd = push0_idx;
      end
      if (acc1 && (wr1_ptr == PTR_W'(s))) begin
        we = 1'b1;
        wd = push1_idx;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ring_q[s] <= (s < INIT_FREE) ? IDX_W'(BASE + LOG + s) : '0;
      end else if (we) begin
        ring_q[s] <= wd;
      end
    end
  end

  assign head_vld = (cnt_q != '0);
  assign head_idx = ring_q[rd_q];
  assign cnt      = cnt_q;

endmodule

// File: rtl/frl_scoreboard.sv
module frl_scoreboard #(
  parameter int NREG     = 14,
  parameter int IDX_W    = 4,
  parameter int INT_LOG  = 4,
  parameter int INT_PHYS = 8,
  parameter int FP_LOG   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr0_en,
  input  logic [IDX_W-1:0] clr0_idx,
  input  logic             clr1_en,
  input  logic [IDX_W-1:0] clr1_idx,
  input  logic             set0_en,
  input  logic [IDX_W-1:0] set0_idx,
  input  logic             set1_en,
  input  logic [IDX_W-1:0] set1_idx,
  input  logic             set2_en,
  input  logic [IDX_W-1:0] set2_idx,
  output logic             dbl_alloc_hit,
  output logic             dbl_free_hit
);
  logic [NREG-1:0] free_q, free_n;

  function automatic logic bit_at(input logic [NREG-1:0] v, input logic [IDX_W-1:0] i);
    return (int'(i) < NREG) ? v[i] : 1'b0;
  endfunction

  always_comb begin
    dbl_alloc_hit = (clr0_en && !bit_at(free_q, clr0_idx)) ||
                    (clr1_en && !bit_at(free_q, clr1_idx));
    dbl_free_hit  = (set0_en && bit_at(free_q, set0_idx)) ||
                    (set1_en && (bit_at(free_q, set1_idx) ||
                                 (set0_en && (set1_idx == set0_idx)))) ||
                    (set2_en && (bit_at(free_q, set2_idx) ||
                                 (set0_en && (set2_idx == set0_idx))));
    free_n = free_q;
    for (int i = 0; i < NREG; i++) begin
      if (clr0_en && (int'(clr0_idx) == i)) free_n[i] = 1'b0;
      if (clr1_en && (int'(clr1_idx) == i)) free_n[i] = 1'b0;
    end
    for (int i = 0; i < NREG; i++) begin
      if (set0_en && (int'(set0_idx) == i)) free_n[i] = 1'b1;
      if (set1_en && (int'(set1_idx) == i)) free_n[i] = 1'b1;
      if (set2_en && (int'(set2_idx) == i)) free_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        free_q[i] <= ((i >= INT_LOG) && (i < INT_PHYS)) || (i >= INT_PHYS + FP_LOG);
      end
    end else begin
      free_q <= free_n;
    end
  end

endmodule

// File: rtl/dual_class_free_list.sv
module dual_class_free_list #(
  parameter  int INT_LOG   = 4,
  parameter  int INT_PHYS  = 8,
  parameter  int FP_LOG    = 3,
  parameter  int FP_PHYS   = 6,
  localparam int TOTAL     = INT_PHYS + FP_PHYS,
  localparam int IDX_W     = frl_pkg::ptr_width(TOTAL),
  localparam int INT_CNT_W = frl_pkg::cnt_width(INT_PHYS),
  localparam int FP_CNT_W  = frl_pkg::cnt_width(FP_PHYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 int_alloc_req,
  output logic                 int_alloc_vld,
  output logic [IDX_W-1:0]     int_alloc_idx,
  input  logic                 fp_alloc_req,
  output logic                 fp_alloc_vld,
  output logic [IDX_W-1:0]     fp_alloc_idx,
  input  logic                 any_rel_en,
  input  logic [IDX_W-1:0]     any_rel_idx,
  input  logic                 int_rel_en,
  input  logic [IDX_W-1:0]     int_rel_idx,
  input  logic                 fp_rel_en,
  input  logic [IDX_W-1:0]     fp_rel_idx,
  output logic                 int_nonempty,
  output logic                 fp_nonempty,
  output logic [INT_CNT_W-1:0] int_free_cnt,
  output logic [FP_CNT_W-1:0]  fp_free_cnt,
  output logic                 empty_alloc_err,
  output logic                 dbl_alloc_err,
  output logic                 dbl_free_err
);

  logic             any_to_int, any_to_fp, int_port_ok, fp_port_ok;
  logic             int_head_vld, fp_head_vld;
  logic [IDX_W-1:0] int_head, fp_head;
  logic             dbl_alloc_hit, dbl_free_hit, empty_hit;
  logic             empty_err_q, dbl_alloc_err_q, dbl_free_err_q;
  logic             empty_err_n, dbl_alloc_err_n, dbl_free_err_n;

  // release steering by index range
  always_comb begin
    any_to_int  = any_rel_en && ({1'b0, any_rel_idx} < (IDX_W+1)'(INT_PHYS));
    any_to_fp   = any_rel_en && ({1'b0, any_rel_idx} >= (IDX_W+1)'(INT_PHYS)) &&
                  ({1'b0, any_rel_idx} < (IDX_W+1)'(TOTAL));
    int_port_ok = int_rel_en && ({1'b0, int_rel_idx} < (IDX_W+1)'(INT_PHYS));
    fp_port_ok  = fp_rel_en && ({1'b0, fp_rel_idx} >= (IDX_W+1)'(INT_PHYS)) &&
                  ({1'b0, fp_rel_idx} < (IDX_W+1)'(TOTAL));
  end

  frl_pool #(
    .IDX_W(IDX_W), .DEPTH(INT_PHYS), .BASE(0), .LOG(INT_LOG), .CNT_W(INT_CNT_W)
  ) u_int_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_req  (int_alloc_req),
    .head_vld (int_head_vld),
    .head_idx (int_head),
    .push0_en (any_to_int),
    .push0_idx(any_rel_idx),
    .push1_en (int_port_ok),
    .push1_idx(int_rel_idx),
    .cnt      (int_free_cnt)
  );

  frl_pool #(
    .IDX_W(IDX_W), .DEPTH(FP_PHYS), .BASE(INT_PHYS), .LOG(FP_LOG), .CNT_W(FP_CNT_W)
  ) u_fp_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_req  (fp_alloc_req),
    .head_vld (fp_head_vld),
    .head_idx (fp_head),
    .push0_en (any_to_fp),
    .push0_idx(any_rel_idx),
    .push1_en (fp_port_ok),
    .push1_idx(fp_rel_idx),
    .cnt      (fp_free_cnt)
  );

  assign int_alloc_vld = int_alloc_req && int_head_vld;
  assign fp_alloc_vld  = fp_alloc_req && fp_head_vld;
  assign int_alloc_idx = int_alloc_vld ? int_head : '0;
  assign fp_alloc_idx  = fp_alloc_vld ? fp_head : '0;
  assign int_nonempty  = int_head_vld;
  assign fp_nonempty   = fp_head_vld;

  frl_scoreboard #(
    .NREG(TOTAL), .IDX_W(IDX_W), .INT_LOG(INT_LOG), .INT_PHYS(INT_PHYS), .FP_LOG(FP_LOG)
  ) u_sb (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr0_en      (int_alloc_vld),
    .clr0_idx     (int_head),
    .clr1_en      (fp_alloc_vld),
    .clr1_idx     (fp_head),
    .set0_en      (any_to_int || any_to_fp),
    .set0_idx     (any_rel_idx),
    .set1_en      (int_port_ok),
    .set1_idx     (int_rel_idx),
    .set2_en      (fp_port_ok),
    .set2_idx     (fp_rel_idx),
    .dbl_alloc_hit(dbl_alloc_hit),
    .dbl_free_hit (dbl_free_hit)
  );

  // sticky error flags: next state
  always_comb begin
    empty_hit       = (int_alloc_req && !int_head_vld) || (fp_alloc_req && !fp_head_vld);
    empty_err_n     = empty_err_q || empty_hit;
    dbl_alloc_err_n = dbl_alloc_err_q || dbl_alloc_hit;
    dbl_free_err_n  = dbl_free_err_q || dbl_free_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_err_q     <= 1'b0;
      dbl_alloc_err_q <= 1'b0;
      dbl_free_err_q  <= 1'b0;
    end else begin
      empty_err_q     <= empty_err_n;
      dbl_alloc_err_q <= dbl_alloc_err_n;
      dbl_free_err_q  <= dbl_free_err_n;
    end
  end

  assign empty_alloc_err = empty_err_q;
  assign dbl_alloc_err   = dbl_alloc_err_q;
  assign dbl_free_err    = dbl_free_err_q;

endmodule

// File: rtl/dual_class_free_list_chk.sv
module dual_class_free_list_chk #(
  parameter  int INT_LOG   = 4,
  parameter  int INT_PHYS  = 8,
  parameter  int FP_LOG    = 3,
  parameter  int FP_PHYS   = 6,
  localparam int TOTAL     = INT_PHYS + FP_PHYS,
  localparam int IDX_W     = frl_pkg::ptr_width(TOTAL),
  localparam int INT_CNT_W = frl_pkg::cnt_width(INT_PHYS),
  localparam int FP_CNT_W  = frl_pkg::cnt_width(FP_PHYS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 int_alloc_req,
  input logic                 int_alloc_vld,
  input logic [IDX_W-1:0]     int_alloc_idx,
  input logic                 fp_alloc_req,
  input logic                 fp_alloc_vld,
  input logic [IDX_W-1:0]     fp_alloc_idx,
  input logic                 any_rel_en,
  input logic [IDX_W-1:0]     any_rel_idx,
  input logic                 int_rel_en,
  input logic [IDX_W-1:0]     int_rel_idx,
  input logic                 fp_rel_en,
  input logic [IDX_W-1:0]     fp_rel_idx,
  input logic [INT_CNT_W-1:0] int_free_cnt,
  input logic [FP_CNT_W-1:0]  fp_free_cnt,
  input logic                 empty_alloc_err,
  input logic                 dbl_alloc_err,
  input logic                 dbl_free_err
);
  logic       any_int, any_fp, any_out, int_cls, fp_cls;
  logic [1:0] int_rel_n, fp_rel_n;

  always_comb begin
    any_int   = any_rel_en && (int'(any_rel_idx) < INT_PHYS);
    any_fp    = any_rel_en && (int'(any_rel_idx) >= INT_PHYS) && (int'(any_rel_idx) < TOTAL);
    any_out   = any_rel_en && (int'(any_rel_idx) >= TOTAL);
    int_cls   = int_rel_en && (int'(int_rel_idx) < INT_PHYS);
    fp_cls    = fp_rel_en && (int'(fp_rel_idx) >= INT_PHYS) && (int'(fp_rel_idx) < TOTAL);
    int_rel_n = 2'(any_int) + 2'(int_cls);
    fp_rel_n  = 2'(any_fp) + 2'(fp_cls);
  end

  assert_int_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_alloc_vld |-> (int'(int_alloc_idx) < INT_PHYS));

  assert_fp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_alloc_vld |-> ((int'(fp_alloc_idx) >= INT_PHYS) && (int'(fp_alloc_idx) < TOTAL)));

  assert_empty_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_alloc_req && (int_free_cnt == '0)) |=> empty_alloc_err);

  assert_empty_fp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_alloc_req && (fp_free_cnt == '0)) |-> !fp_alloc_vld);

  assert_sticky_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    empty_alloc_err |=> empty_alloc_err);

  assert_sticky_dalloc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_alloc_err |=> dbl_alloc_err);

  assert_sticky_dfree_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_free_err |=> dbl_free_err);

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(int_free_cnt) <= INT_PHYS) && (int'(fp_free_cnt) <= FP_PHYS));

  assert_int_balance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_alloc_vld && (int_rel_n == 2'd1)) |=> (int_free_cnt == $past(int_free_cnt)));

  assert_fp_balance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_alloc_vld && (fp_rel_n == 2'd1)) |=> (fp_free_cnt == $past(fp_free_cnt)));

  assert_out_range_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_out && !int_rel_en && !fp_rel_en && !int_alloc_req && !fp_alloc_req)
    |=> ((int_free_cnt == $past(int_free_cnt)) && (fp_free_cnt == $past(fp_free_cnt))));

endmodule

bind dual_class_free_list dual_class_free_list_chk #(
  .INT_LOG(INT_LOG), .INT_PHYS(INT_PHYS), .FP_LOG(FP_LOG), .FP_PHYS(FP_PHYS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .int_alloc_req  (int_alloc_req),
  .int_alloc_vld  (int_alloc_vld),
  .int_alloc_idx  (int_alloc_idx),
  .fp_alloc_req   (fp_alloc_req),
  .fp_alloc_vld   (fp_alloc_vld),
  .fp_alloc_idx   (fp_alloc_idx),
  .any_rel_en     (any_rel_en),
  .any_rel_idx    (any_rel_idx),
  .int_rel_en     (int_rel_en),
  .int_rel_idx    (int_rel_idx),
  .fp_rel_en      (fp_rel_en),
  .fp_rel_idx     (fp_rel_idx),
  .int_free_cnt   (int_free_cnt),
  .fp_free_cnt    (fp_free_cnt),
  .empty_alloc_err(empty_alloc_err),
  .dbl_alloc_err  (dbl_alloc_err),
  .dbl_free_err   (dbl_free_err)
);

// File: tb/dual_class_free_list_tb.sv
module dual_class_free_list_tb;

  logic       clk, rst_n;
  logic       int_alloc_req, fp_alloc_req;
  logic       int_alloc_vld, fp_alloc_vld;
  logic [3:0] int_alloc_idx, fp_alloc_idx;
  logic       any_rel_en, int_rel_en, fp_rel_en;
  logic [3:0] any_rel_idx, int_rel_idx, fp_rel_idx;
  logic       int_nonempty, fp_nonempty;
  logic [3:0] int_free_cnt;
  logic [2:0] fp_free_cnt;
  logic       empty_alloc_err, dbl_alloc_err, dbl_free_err;

  int checks = 0;
  int errors = 0;

  dual_class_free_list #(.INT_LOG(4), .INT_PHYS(8), .FP_LOG(3), .FP_PHYS(6)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .int_alloc_req(int_alloc_req), .int_alloc_vld(int_alloc_vld), .int_alloc_idx(int_alloc_idx),
    .fp_alloc_req(fp_alloc_req), .fp_alloc_vld(fp_alloc_vld), .fp_alloc_idx(fp_alloc_idx),
    .any_rel_en(any_rel_en), .any_rel_idx(any_rel_idx),
    .int_rel_en(int_rel_en), .int_rel_idx(int_rel_idx),
    .fp_rel_en(fp_rel_en), .fp_rel_idx(fp_rel_idx),
    .int_nonempty(int_nonempty), .fp_nonempty(fp_nonempty),
    .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt),
    .empty_alloc_err(empty_alloc_err), .dbl_alloc_err(dbl_alloc_err), .dbl_free_err(dbl_free_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       ireq; logic freq;
    logic       gen;  logic [3:0] gidx;
    logic       ien;  logic [3:0] iidx;
    logic       fen;  logic [3:0] fidx;
    logic       eiv;  logic [3:0] eii;
    logic       efv;  logic [3:0] efi;
    logic [3:0] eic;  logic [2:0] efc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd4, 1'b0,4'd0,  4'd3,3'd3}, // R2 int head 4
    '{1'b0,1'b1, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b0,4'd0, 1'b1,4'd11, 4'd3,3'd2}, // R3 fp head 11
    '{1'b1,1'b1, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd5, 1'b1,4'd12, 4'd2,3'd1}, // R2 both
    '{1'b0,1'b0, 1'b1,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  4'd3,3'd1}, // R4 gen->int
    '{1'b0,1'b0, 1'b1,4'd8,  1'b0,4'd0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  4'd3,3'd2}, // R4 gen->fp
    '{1'b0,1'b0, 1'b1,4'd15, 1'b0,4'd0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  4'd3,3'd2}, // R4 out of range
    '{1'b1,1'b0, 1'b1,4'd4,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd6, 1'b0,4'd0,  4'd3,3'd2}, // R6 int
    '{1'b0,1'b1, 1'b0,4'd0,  1'b0,4'd0, 1'b1,4'd11, 1'b0,4'd0, 1'b1,4'd13, 4'd3,3'd2}, // R6 fp
    '{1'b0,1'b0, 1'b0,4'd0,  1'b1,4'd9, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  4'd3,3'd2}, // R5 wrong class
    '{1'b0,1'b0, 1'b0,4'd0,  1'b0,4'd0, 1'b1,4'd2,  1'b0,4'd0, 1'b0,4'd0,  4'd3,3'd2}, // R5 wrong class
    '{1'b0,1'b0, 1'b1,4'd1,  1'b1,4'd2, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  4'd5,3'd2}, // R12 dual push
    '{1'b1,1'b0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd7, 1'b0,4'd0,  4'd4,3'd2}, // R2
    '{1'b1,1'b0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd0, 1'b0,4'd0,  4'd3,3'd2}, // R2
    '{1'b1,1'b0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd4, 1'b0,4'd0,  4'd2,3'd2}, // R2
    '{1'b1,1'b0, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd1, 1'b0,4'd0,  4'd1,3'd2}, // R12 order
    '{1'b0,1'b1, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b0,4'd0, 1'b1,4'd8,  4'd1,3'd1}, // R2 fp
    '{1'b1,1'b1, 1'b0,4'd0,  1'b0,4'd0, 1'b0,4'd0,  1'b1,4'd2, 1'b1,4'd11, 4'd0,3'd0}  // R12 / R10
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    int_alloc_req = 1'b0; fp_alloc_req = 1'b0;
    any_rel_en = 1'b0; any_rel_idx = '0;
    int_rel_en = 1'b0; int_rel_idx = '0;
    fp_rel_en  = 1'b0; fp_rel_idx  = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One int alloc; check granted index before the edge.
  task automatic int_take(input string req, input int exp_idx);
    @(negedge clk);
    idle();
    int_alloc_req = 1'b1;
    #2;
    check(req, int_alloc_vld, 1);
    check(req, int_alloc_idx, exp_idx);
    @(posedge clk);
    #2;
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    do_reset();
    #2;
    // R1 reset state
    check("R1 int cnt", int_free_cnt, 4);
    check("R1 fp cnt", fp_free_cnt, 3);
    check("R1 int nonempty", int_nonempty, 1);
    check("R1 fp nonempty", fp_nonempty, 1);
    check("R1 errs", {empty_alloc_err, dbl_alloc_err, dbl_free_err}, 0);

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      int_alloc_req = VECS[n].ireq; fp_alloc_req = VECS[n].freq;
      any_rel_en = VECS[n].gen;  any_rel_idx = VECS[n].gidx;
      int_rel_en = VECS[n].ien;  int_rel_idx = VECS[n].iidx;
      fp_rel_en  = VECS[n].fen;  fp_rel_idx  = VECS[n].fidx;
      #2;
      check($sformatf("R2 vec%0d int vld", n), int_alloc_vld, VECS[n].eiv);
      check($sformatf("R2 vec%0d int idx", n), int_alloc_idx, VECS[n].eii);
      check($sformatf("R3 vec%0d fp vld", n), fp_alloc_vld, VECS[n].efv);
      check($sformatf("R3 vec%0d fp idx", n), fp_alloc_idx, VECS[n].efi);
      @(posedge clk);
      #2;
      check($sformatf("R10 vec%0d int cnt", n), int_free_cnt, VECS[n].eic);
      check($sformatf("R10 vec%0d fp cnt", n), fp_free_cnt, VECS[n].efc);
      check($sformatf("R10 vec%0d int ne", n), int_nonempty, VECS[n].eic != 0);
      check($sformatf("R10 vec%0d fp ne", n), fp_nonempty, VECS[n].efc != 0);
    end
    @(negedge clk);
    idle();
    check("R8 no false free err", dbl_free_err, 0);
    check("R9 no false alloc err", dbl_alloc_err, 0);
    check("R7 no false empty err", empty_alloc_err, 0);

    // R7: request to empty int pool
    @(negedge clk);
    int_alloc_req = 1'b1;
    #2;
    check("R7 empty vld", int_alloc_vld, 0);
    check("R7 empty idx", int_alloc_idx, 0);
    @(posedge clk);
    #2;
    idle();
    check("R7 empty err", empty_alloc_err, 1);
    check("R7 cnt stays", int_free_cnt, 0);
    // R11: remains set
    repeat (3) @(posedge clk);
    #2;
    check("R11 sticky", empty_alloc_err, 1);

    // R1 again after reset; R11 flag cleared only by reset
    do_reset();
    #2;
    check("R11 cleared by reset", empty_alloc_err, 0);
    check("R1 int cnt again", int_free_cnt, 4);

    // R8: release a register that is already free
    @(negedge clk);
    any_rel_en = 1'b1; any_rel_idx = 4'd5;
    @(posedge clk);
    #2;
    idle();
    check("R8 dbl free err", dbl_free_err, 1);
    check("R8 still pushed", int_free_cnt, 5);
    // R9: the duplicate 5 is granted twice
    int_take("R2 after dup", 4);
    int_take("R2 after dup", 5);
    int_take("R2 after dup", 6);
    int_take("R2 after dup", 7);
    check("R9 no err yet", dbl_alloc_err, 0);
    int_take("R9 dup grant", 5);
    check("R9 dbl alloc err", dbl_alloc_err, 1);
    check("R11 free err held", dbl_free_err, 1);

    // R7 fp empty after reset, R1 fp order
    do_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      fp_alloc_req = 1'b1;
      #2;
      check("R1 fp init order", fp_alloc_idx, 11 + k);
      @(posedge clk);
      #2;
      idle();
    end
    @(negedge clk);
    fp_alloc_req = 1'b1;
    #2;
    check("R7 fp empty vld", fp_alloc_vld, 0);
    @(posedge clk);
    #2;
    idle();
    check("R7 fp empty err", empty_alloc_err, 1);
    check("R10 fp ne low", fp_nonempty, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule